// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Full and Partial Reset

A single-clock FIFO whose read-side behaviour is picked once, while the full reset is held. In standard mode a read strobe moves the oldest stored word into a registered output. The two status outputs then act as an active-low empty indication and an active-low full indication. In fall-through mode the oldest word is shown on the output without any read. A read strobe takes that word and advances to the next one. The same two status outputs then act as an active-low output-valid indication and an active-low input-ready indication.

Three further active-low flags report the fill level: almost-empty, almost-full and more-than-half-full. The almost-empty and almost-full thresholds are held in offset registers. A full reset loads them from parameter defaults, and a parallel load strobe can rewrite them. There are two active-low asynchronous resets:
- The full reset clears the storage and latches the mode input.
- The partial reset clears the storage, the flags and the output register, but keeps the mode and the offsets. It is meant for flushing the FIFO in operation without reprogramming it.

Top module: `dual_mode_fifo`

## Requirements
- R1: While or after `rst_ni` is low, the FIFO holds no words and `rd_data_o` is all zeroes.
- R2: While either reset is low, `pae_no` is 0, `paf_no` is 1 and `hf_no` is 1.
- R3: `fwft_sel_i` is sampled only while `rst_ni` is low; 0 selects standard mode. In standard mode `out_stat_o` is 0 exactly when the FIFO is empty and `in_stat_o` is 1 exactly when it is not full, so after reset `out_stat_o`=0 and `in_stat_o`=1. Changing `fwft_sel_i` after reset has no effect.
- R4: `fwft_sel_i`=1 during full reset selects fall-through mode. Here `out_stat_o` is 0 exactly when a valid word is on `rd_data_o` and `in_stat_o` is 0 exactly when the FIFO is not full, so after reset `out_stat_o`=1 and `in_stat_o`=0.
- R5: `prst_ni` low empties the FIFO and clears `rd_data_o` to zero. It keeps the selected mode and both offset values.
- R6: `wr_en_i` has no effect while either reset is low.
- R7: In standard mode, `rd_en_i` at a clock edge with the FIFO non-empty puts the oldest word on `rd_data_o` after that edge. A read when empty is ignored and `rd_data_o` holds its value.
- R8: In fall-through mode the oldest stored word is on `rd_data_o` without a read; a word written into an empty FIFO is shown after the write edge. `rd_en_i` with a valid word removes it. When the last word is removed `rd_data_o` keeps it and `out_stat_o` returns to 1.
- R9: The stored count counts written words not yet removed, including the word on the output in fall-through mode. Writes are accepted only while it is below `DEPTH`, even when a read occurs in the same cycle. At `DEPTH` the full indication is shown and further writes are dropped.
- R10: `pae_no` is 0 exactly when the stored count is at most the almost-empty offset.
- R11: `paf_no` is 0 exactly when the stored count is at least `DEPTH` minus the almost-full offset.
- R12: `hf_no` is 0 exactly when the stored count exceeds `DEPTH`/2.
- R13: `ofs_ld_i` high at a clock edge loads `ae_ofs_i` and `af_ofs_i` into the offset registers. A full reset restores `AE_DEF` and `AF_DEF`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Full reset, active low, asynchronous; latches mode |
| prst_ni | input | 1 | Partial reset, active low, asynchronous |
| fwft_sel_i | input | 1 | Mode select sampled during full reset (1 = fall-through) |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DW | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | DW | Registered output data |
| ofs_ld_i | input | 1 | Offset load strobe |
| ae_ofs_i | input | $clog2(DEPTH) | Almost-empty offset to load |
| af_ofs_i | input | $clog2(DEPTH) | Almost-full offset to load |
| out_stat_o | output | 1 | Empty (standard) or output-not-valid (fall-through), active low meaning per R3/R4 |
| in_stat_o | output | 1 | Not-full (standard) or input-not-ready (fall-through) |
| pae_no | output | 1 | Almost-empty, active low |
| paf_no | output | 1 | Almost-full, active low |
| hf_no | output | 1 | Over half full, active low |

## Verification
The bench builds the FIFO with `DEPTH`=8, `DW`=8, `AE_DEF`=1 and `AF_DEF`=2. With this shallow depth every flag threshold, the half-full point and the full boundary can be reached in a few writes, in both modes. The almost-full threshold of 6 and the half-full threshold above 4 differ from each other and from a reloaded offset pair of 3 and 1. A stray reload of defaults after a partial reset, or a mix-up between the two offsets, therefore changes a flag at a count the bench checks.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;
endpackage

// File: rtl/fifo_cfg.sv
module fifo_cfg
  import fifo_pkg::*;
#(
  parameter int unsigned AW     = 3,
  parameter int unsigned AE_DEF = 1,
  parameter int unsigned AF_DEF = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fwft_sel_i,
  input  logic          ld_i,
  input  logic [AW-1:0] ae_i,
  input  logic [AW-1:0] af_i,
  output fifo_mode_e    mode_o,
  output logic [AW-1:0] ae_o,
  output logic [AW-1:0] af_o
);
  fifo_mode_e    mode_q;
  logic [AW-1:0] ae_q, af_q;

  // mode follows the select pin for as long as full reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= fwft_sel_i ? MODE_FWFT : MODE_STD;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ae_q <= AW'(AE_DEF);
      af_q <= AW'(AF_DEF);
    end else if (ld_i) begin
      ae_q <= ae_i;
      af_q <= af_i;
    end
  end

  assign mode_o = mode_q;
  assign ae_o   = ae_q;
  assign af_o   = af_q;

  // R3: mode is frozen outside full reset
  a_r3_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> $stable(mode_q));
endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] cnt_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (pop_i)  rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o = mem_q[rptr_q];
  assign cnt_o  = cnt_q;

  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  a_r9_push_has_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> (cnt_q < CW'(DEPTH)));
  a_r7_pop_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0));
endmodule

// File: rtl/fifo_outreg.sv
module fifo_outreg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_head_i,
  input  logic          bypass_i,
  input  logic          drop_i,
  input  logic [DW-1:0] head_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o
);
  logic [DW-1:0] data_q;
  logic          valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (take_head_i)   data_q <= head_i;
      else if (bypass_i) data_q <= wr_data_i;
      if (take_head_i || bypass_i) valid_q <= 1'b1;
      else if (drop_i)             valid_q <= 1'b0;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/fifo_flags.sv
module fifo_flags #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          fwft_i,
  input  logic [CW-1:0] total_i,
  input  logic [AW-1:0] ae_i,
  input  logic [AW-1:0] af_i,
  output logic          full_o,
  output logic          out_stat_o,
  output logic          in_stat_o,
  output logic          pae_no,
  output logic          paf_no,
  output logic          hf_no
);
  logic empty;
  logic [CW-1:0] af_lvl;

  assign empty  = (total_i == '0);
  assign full_o = (total_i >= CW'(DEPTH));
  assign af_lvl = CW'(DEPTH) - {1'b0, af_i};

  assign out_stat_o = fwft_i ? empty  : !empty;
  assign in_stat_o  = fwft_i ? full_o : !full_o;
  assign pae_no     = !(total_i <= {1'b0, ae_i});
  assign paf_no     = !(total_i >= af_lvl);
  assign hf_no      = !(total_i > CW'(DEPTH / 2));
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
  import fifo_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned AE_DEF = 1,
  parameter int unsigned AF_DEF = 2,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prst_ni,
  input  logic          fwft_sel_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          ofs_ld_i,
  input  logic [AW-1:0] ae_ofs_i,
  input  logic [AW-1:0] af_ofs_i,
  output logic          out_stat_o,
  output logic          in_stat_o,
  output logic          pae_no,
  output logic          paf_no,
  output logic          hf_no
);
  fifo_mode_e    mode;
  logic [AW-1:0] ae_ofs, af_ofs;
  logic          fwft, full, any_rst_n;
  logic [CW-1:0] mem_cnt, total;
  logic [DW-1:0] head;
  logic          ov, push, pop, std_pop, load_mem, bypass, drop, need_load, wr_ok;

  assign any_rst_n = rst_ni & prst_ni;
  assign fwft      = (mode == MODE_FWFT);

  fifo_cfg #(.AW(AW), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) i_cfg (
    .clk_i, .rst_ni, .fwft_sel_i,
    .ld_i(ofs_ld_i), .ae_i(ae_ofs_i), .af_i(af_ofs_i),
    .mode_o(mode), .ae_o(ae_ofs), .af_o(af_ofs)
  );

  fifo_store #(.DW(DW), .DEPTH(DEPTH)) i_store (
    .clk_i, .rst_ni(any_rst_n),
    .push_i(push), .push_data_i(wr_data_i), .pop_i(pop),
    .head_o(head), .cnt_o(mem_cnt)
  );

  // word on the output counts as stored only in fall-through mode
  assign total = mem_cnt + CW'(fwft & ov);
  assign wr_ok = wr_en_i && !full;

  always_comb begin
    std_pop   = 1'b0;
    load_mem  = 1'b0;
    bypass    = 1'b0;
    drop      = 1'b0;
    need_load = 1'b0;
    if (fwft) begin
      drop      = rd_en_i && ov;
      need_load = !ov || drop;
      load_mem  = need_load && (mem_cnt != '0);
      bypass    = need_load && (mem_cnt == '0) && wr_ok;
    end else begin
      std_pop   = rd_en_i && (mem_cnt != '0);
    end
    pop  = std_pop || load_mem;
    push = wr_ok && !bypass;
  end

  fifo_outreg #(.DW(DW)) i_out (
    .clk_i, .rst_ni(any_rst_n),
    .take_head_i(pop), .bypass_i(bypass), .drop_i(drop),
    .head_i(head), .wr_data_i(wr_data_i),
    .data_o(rd_data_o), .valid_o(ov)
  );

  fifo_flags #(.DEPTH(DEPTH)) i_flags (
    .fwft_i(fwft), .total_i(total), .ae_i(ae_ofs), .af_i(af_ofs),
    .full_o(full), .out_stat_o, .in_stat_o, .pae_no, .paf_no, .hf_no
  );

  // R8: memory never holds words behind an empty output stage
  a_r8_stored_implies_valid: assert property (@(posedge clk_i) disable iff (!any_rst_n)
    (fwft && mem_cnt != '0) |-> ov);
  // R8: a removed word is replaced the same edge when memory has one
  a_r8_refill: assert property (@(posedge clk_i) disable iff (!any_rst_n)
    (fwft && ov && rd_en_i && mem_cnt > CW'(1)) |=> ov);
endmodule

// File: tb/test_dual_mode_fifo.sv
module test_dual_mode_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8, DEPTH = 8, AE_DEF = 1, AF_DEF = 2;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0, prst_n = 1'b1, fwft_sel = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, ofs_ld = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] ae_ofs = '0, af_ofs = '0;
  logic [DW-1:0] rd_data;
  logic out_stat, in_stat, pae_n, paf_n, hf_n;

  dual_mode_fifo #(.DW(DW), .DEPTH(DEPTH), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) i_dual_mode_fifo (
    .clk_i(clk), .rst_ni(rst_n), .prst_ni(prst_n), .fwft_sel_i(fwft_sel),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .ofs_ld_i(ofs_ld), .ae_ofs_i(ae_ofs), .af_ofs_i(af_ofs),
    .out_stat_o(out_stat), .in_stat_o(in_stat), .pae_no(pae_n), .paf_no(paf_n), .hf_no(hf_n)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int total = 0, bad = 0;
  int q[$];
  bit m_fwft = 0;
  int m_ae = AE_DEF, m_af = AF_DEF, m_dout = 0;
  string ph = "R1";

  task automatic chk(string tag, string sig, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, sig, act, exp);
    end
  endtask

  task automatic compare();
    int n = q.size();
    bit full = (n >= DEPTH);
    chk(ph, "rd_data", int'(rd_data), m_dout);
    chk(ph, "out_stat", int'(out_stat), m_fwft ? int'(n == 0) : int'(n != 0));
    chk(ph, "in_stat", int'(in_stat), m_fwft ? int'(full) : int'(!full));
    chk("R10", "pae_n", int'(pae_n), int'(!(n <= m_ae)));
    chk("R11", "paf_n", int'(paf_n), int'(!(n >= DEPTH - m_af)));
    chk("R12", "hf_n", int'(hf_n), int'(!(n > DEPTH / 2)));
  endtask

  task automatic step(bit w, int wd, bit r);
    bit can;
    wr_en = w; wr_data = DW'(wd); rd_en = r;
    @(posedge clk); #1;
    if (rst_n && prst_n) begin
      can = (q.size() < DEPTH);
      if (r && q.size() > 0) begin
        if (m_fwft) void'(q.pop_front());
        else m_dout = q.pop_front();
      end
      if (w && can) q.push_back(wd & 8'hff);
      if (m_fwft && q.size() > 0) m_dout = q[0];
      if (ofs_ld) begin m_ae = int'(ae_ofs); m_af = int'(af_ofs); end
    end
    compare();
    wr_en = 0; rd_en = 0;
  endtask

  task automatic full_reset(bit sel);
    rst_n = 0; fwft_sel = sel;
    q.delete(); m_dout = 0; m_fwft = sel; m_ae = AE_DEF; m_af = AF_DEF;
    ph = "R1";
    step(1, 99, 0);
    chk("R1", "rd_data", int'(rd_data), 0);
    chk("R2", "pae_n", int'(pae_n), 0);
    chk("R2", "paf_n", int'(paf_n), 1);
    chk("R2", "hf_n", int'(hf_n), 1);
    chk(sel ? "R4" : "R3", "out_stat", int'(out_stat), sel ? 1 : 0);
    chk(sel ? "R4" : "R3", "in_stat", int'(in_stat), sel ? 0 : 1);
    rst_n = 1;
    step(0, 0, 0);
  endtask

  task automatic partial_reset();
    prst_n = 0;
    q.delete(); m_dout = 0;
    ph = "R6";
    step(1, 77, 0);
    step(1, 78, 0);
    chk("R5", "rd_data", int'(rd_data), 0);
    chk("R2", "pae_n", int'(pae_n), 0);
    chk("R2", "hf_n", int'(hf_n), 1);
    prst_n = 1;
    step(0, 0, 0);
    chk("R6", "out_stat", int'(out_stat), m_fwft ? 1 : 0);
    chk("R5", "in_stat", int'(in_stat), m_fwft ? 0 : 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    full_reset(0);
    fwft_sel = 1;   // R3: ignored after reset
    partial_reset();

    ph = "R9";
    for (int i = 0; i < DEPTH + 2; i++) step(1, 16 + i, 0);
    chk("R9", "in_stat_full", int'(in_stat), 0);
    ph = "R7";
    for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 1);
    chk("R7", "rd_data_hold", int'(rd_data), 16 + DEPTH - 1);
    for (int i = 0; i < 4; i++) step(1, 40 + i, (i > 0));

    ph = "R13";
    ofs_ld = 1; ae_ofs = 3; af_ofs = 1;
    step(0, 0, 0);
    ofs_ld = 0;
    for (int i = 0; i < DEPTH; i++) step(1, 50 + i, 0);

    partial_reset();
    ph = "R5";
    for (int i = 0; i < 3; i++) step(1, 60 + i, 0);
    chk("R5", "pae_n_kept_ofs", int'(pae_n), 0);
    step(1, 63, 0);
    chk("R5", "pae_n_kept_ofs", int'(pae_n), 1);
    for (int i = 0; i < 2; i++) step(1, 64 + i, 0);
    chk("R5", "paf_n_kept_ofs", int'(paf_n), 1);
    step(1, 66, 0);
    chk("R5", "paf_n_kept_ofs", int'(paf_n), 0);

    full_reset(1);
    fwft_sel = 0;
    ph = "R8";
    step(1, 123, 0);
    chk("R8", "fall_through_data", int'(rd_data), 123);
    chk("R8", "out_stat_valid", int'(out_stat), 0);
    step(1, 124, 0);
    chk("R13", "pae_n_default", int'(pae_n), 1);
    ph = "R9";
    for (int i = 0; i < DEPTH; i++) step(1, 130 + i, 0);
    chk("R9", "in_stat_full", int'(in_stat), 1);
    step(1, 200, 1);
    ph = "R8";
    for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 1);
    chk("R8", "out_stat_drained", int'(out_stat), 1);

    partial_reset();
    ph = "R8";
    for (int i = 0; i < 400; i++) step(bit'($urandom_range(0, 1)), $urandom_range(0, 255), bit'($urandom_range(0, 1)));

    full_reset(0);
    ph = "R7";
    for (int i = 0; i < 400; i++) step(bit'($urandom_range(0, 1)), $urandom_range(0, 255), bit'($urandom_range(0, 1)));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule